// File: doc/BRIEF.md
# Destination Address Filter

This block sits on the receive side of an Ethernet MAC. It decides whether a frame is kept by looking at the 48-bit destination address that opens the frame. Frame bytes arrive one per cycle on a qualified byte stream. A start marker flags the first byte. Once the sixth address byte has been taken, the block issues a single-cycle decision strobe with an accept flag.

Software sets the filter up through a simple write port. Three settings are available:
- a mode word with pass-all-unicast, pass-all-multicast, pass-broadcast and exact-compare controls;
- an enable word with one bit per table slot;
- a table of exact addresses, each stored as a high word and a low word.

All settings are copied into an active set at each start marker. A frame is therefore judged by the settings that were in place when it began.

Top module: `dest_addr_filter`

## Requirements
- R1: Table slot n (n = 0..15) has its high word at offset 0x08 + 8n and its low word at offset 0x0C + 8n. In the high word, address byte 0 sits in bits 31:24, byte 1 in 23:16, byte 2 in 15:8 and byte 3 in 7:0. In the low word, byte 4 sits in bits 31:24 and byte 5 in 23:16. Low-word bits 15:0 are ignored.
- R2: Bit n of the enable word at offset 0x04 enables slot n. A disabled slot never matches.
- R3: The mode word at offset 0x00 uses these bits:
  - bit 0 passes every unicast address;
  - bit 1 passes every multicast address;
  - bit 2 passes broadcast;
  - bit 4 enables exact comparison against the enabled slots.
  Bit 3 and all other bits have no effect.
- R4: The first byte received is address byte 0. The address is classified as follows:
  - broadcast when all 48 bits are 1;
  - multicast when bit 0 of byte 0 is 1 and the address is not broadcast;
  - unicast when bit 0 of byte 0 is 0.
- R5: A frame is accepted when any of these holds:
  - its class has its pass bit set;
  - exact comparison is on and an enabled slot equals the address.
  With all four mode bits set every frame is accepted. With only compare and broadcast set, only broadcast and table hits are accepted.
- R6: `dec_valid` is high for exactly one cycle per frame, in the cycle after the clock edge that follows the edge taking the sixth address byte. Bytes after the sixth have no effect.
- R7: A start marker received partway through an address restarts collection with that byte as byte 0. The abandoned partial address produces no decision.
- R8: A register write made while a frame is in progress does not affect that frame's decision; it applies from the next start marker on.
- R9: After reset both outputs are 0 and every register is cleared, so every frame is rejected.
- R10: `dec_accept` is 0 whenever `dec_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | AW | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| rx_valid | input | 1 | Qualifies `rx_byte` |
| rx_sof | input | 1 | Marks the first byte of a frame |
| rx_byte | input | 8 | Frame byte |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_accept | output | 1 | Frame accepted, meaningful with `dec_valid` |

## Verification
The assertions take for granted that `rx_sof` is only ever raised together with `rx_valid`. They also assume that no new start marker arrives in the cycle right after a sixth address byte, since that is the cycle in which the active settings are read for the decision. The stimulus respects both assumptions. Every frame is separated from the next by at least two idle cycles, and restarts only happen before the sixth byte. Register writes inside a frame are placed at least two cycles after the start marker.

// File: rtl/daf_pkg.sv
package daf_pkg;
  localparam int DA_BYTES   = 6;
  localparam int DA_W       = 8 * DA_BYTES;
  localparam int MC_BIT     = DA_W - 8;   // bit 0 of the first byte
  localparam int OFS_MODE   = 'h00;
  localparam int OFS_EN     = 'h04;
  localparam int OFS_TAB    = 'h08;
  localparam int TAB_STRIDE = 8;
  localparam int LO_OFS     = 4;
  localparam int BIT_UC     = 0;
  localparam int BIT_MC     = 1;
  localparam int BIT_BC     = 2;
  localparam int BIT_CMP    = 4;

  typedef logic [DA_W-1:0] mac_t;

  typedef struct packed {
    logic cmp;
    logic bc;
    logic mc;
    logic uc;
  } mode_t;
endpackage

// File: rtl/daf_regs.sv
module daf_regs
  import daf_pkg::*;
#(
  parameter int NUM_ENT = 16,
  parameter int AW      = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_addr,
  input  logic [31:0]            wr_data,
  input  logic                   snap,
  output mode_t                  act_mode,
  output logic [NUM_ENT-1:0]     act_en,
  output mac_t [NUM_ENT-1:0]     act_tab
);
  localparam int LO_W = DA_W - 32;

  mode_t                          live_mode;
  logic [NUM_ENT-1:0]             live_en;
  logic [NUM_ENT-1:0][31:0]       live_hi;
  logic [NUM_ENT-1:0][LO_W-1:0]   live_lo;
  mac_t [NUM_ENT-1:0]             live_tab;

  always_ff @(posedge clk) begin
    if (rst) begin
      live_mode <= '0;
      live_en   <= '0;
      live_hi   <= '0;
      live_lo   <= '0;
    end else if (wr_en) begin
      if (wr_addr == AW'(OFS_MODE)) begin
        live_mode.uc  <= wr_data[BIT_UC];
        live_mode.mc  <= wr_data[BIT_MC];
        live_mode.bc  <= wr_data[BIT_BC];
        live_mode.cmp <= wr_data[BIT_CMP];
      end
      if (wr_addr == AW'(OFS_EN))
        live_en <= wr_data[NUM_ENT-1:0];
      for (int i = 0; i < NUM_ENT; i++) begin
        if (wr_addr == AW'(OFS_TAB + TAB_STRIDE * i))
          live_hi[i] <= wr_data;
        if (wr_addr == AW'(OFS_TAB + TAB_STRIDE * i + LO_OFS))
          live_lo[i] <= wr_data[31 -: LO_W];
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_ENT; g++) begin : g_join
      assign live_tab[g] = {live_hi[g], live_lo[g]};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      act_mode <= '0;
      act_en   <= '0;
      act_tab  <= '0;
    end else if (snap) begin
      act_mode <= live_mode;
      act_en   <= live_en;
      act_tab  <= live_tab;
    end
  end
endmodule

// File: rtl/daf_collect.sv
module daf_collect
  import daf_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic       in_sof,
  input  logic [7:0] in_byte,
  output mac_t       da,
  output logic       done
);
  localparam int CW = $clog2(DA_BYTES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= CW'(DA_BYTES);
      da   <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (in_valid) begin
        if (in_sof) begin
          da  <= {da[DA_W-9:0], in_byte};
          cnt <= CW'(1);
          if (DA_BYTES == 1) done <= 1'b1;
        end else if (cnt < CW'(DA_BYTES)) begin
          da  <= {da[DA_W-9:0], in_byte};
          cnt <= cnt + 1'b1;
          if (cnt == CW'(DA_BYTES - 1)) done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/daf_match.sv
module daf_match
  import daf_pkg::*;
#(
  parameter int NUM_ENT = 16
) (
  input  mac_t                da,
  input  mode_t               mode,
  input  logic [NUM_ENT-1:0]  en,
  input  mac_t [NUM_ENT-1:0]  tab,
  output logic                accept
);
  logic [NUM_ENT-1:0] hit;
  logic is_bc, is_mc, is_uc;

  genvar g;
  generate
    for (g = 0; g < NUM_ENT; g++) begin : g_cmp
      assign hit[g] = en[g] && (tab[g] == da);
    end
  endgenerate

  always_comb begin
    is_bc  = &da;
    is_mc  = da[MC_BIT] & ~is_bc;
    is_uc  = ~da[MC_BIT];
    accept = (mode.uc & is_uc) | (mode.mc & is_mc) |
             (mode.bc & is_bc) | (mode.cmp & (|hit));
  end
endmodule

// File: rtl/dest_addr_filter.sv
module dest_addr_filter
  import daf_pkg::*;
#(
  parameter int NUM_ENT = 16,
  parameter int AW      = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [31:0]   cfg_wdata,
  input  logic          rx_valid,
  input  logic          rx_sof,
  input  logic [7:0]    rx_byte,
  output logic          dec_valid,
  output logic          dec_accept
);
  mode_t               act_mode;
  logic [NUM_ENT-1:0]  act_en;
  mac_t [NUM_ENT-1:0]  act_tab;
  mac_t                col_da;
  logic                col_done;
  logic                match_acc;
  logic                snap;

  assign snap = rx_valid & rx_sof;

  daf_regs #(.NUM_ENT(NUM_ENT), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(cfg_we), .wr_addr(cfg_addr),
    .wr_data(cfg_wdata), .snap(snap),
    .act_mode(act_mode), .act_en(act_en), .act_tab(act_tab)
  );

  daf_collect u_collect (
    .clk(clk), .rst(rst), .in_valid(rx_valid), .in_sof(rx_sof),
    .in_byte(rx_byte), .da(col_da), .done(col_done)
  );

  daf_match #(.NUM_ENT(NUM_ENT)) u_match (
    .da(col_da), .mode(act_mode), .en(act_en), .tab(act_tab),
    .accept(match_acc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
    end else begin
      dec_valid  <= col_done;
      dec_accept <= col_done & match_acc;
    end
  end
endmodule

// File: rtl/daf_checker.sv
module daf_checker
  import daf_pkg::*;
(
  input logic  clk,
  input logic  rst,
  input logic  rx_valid,
  input logic  rx_sof,
  input logic  dec_valid,
  input logic  dec_accept,
  input mac_t  da,
  input mode_t mode
);
  p_single_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    dec_valid |=> !dec_valid);

  p_latency_r6: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> $past(rx_valid, 2));

  p_accept_qual_r10: assert property (@(posedge clk) disable iff (rst)
    !dec_valid |-> !dec_accept);

  p_bcast_pass_r5: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && (&$past(da)) && $past(mode.bc)) |-> dec_accept);

  p_all_off_r9: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && ($past(mode) == '0)) |-> !dec_accept);

  p_hold_mode_r8: assert property (@(posedge clk) disable iff (rst)
    !(rx_valid && rx_sof) |=> $stable(mode));
endmodule

bind dest_addr_filter daf_checker u_chk (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sof(rx_sof),
  .dec_valid(dec_valid), .dec_accept(dec_accept),
  .da(col_da), .mode(act_mode)
);

// File: tb/dest_addr_filter_tb.sv
module dest_addr_filter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        rx_valid = 1'b0;
  logic        rx_sof = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        dec_valid, dec_accept;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  logic [3:0]  m_mode;  // {cmp, bc, mc, uc}
  logic [15:0] m_en;
  logic [47:0] m_tab [NE];

  always #(CLK_PERIOD/2) clk = ~clk;

  dest_addr_filter #(.NUM_ENT(NE), .AW(8)) u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_byte(rx_byte), .dec_valid(dec_valid), .dec_accept(dec_accept)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic void mirror_wr(input logic [7:0] a, input logic [31:0] d);
    if (a == 8'h00) m_mode = {d[4], d[2], d[1], d[0]};
    else if (a == 8'h04) m_en = d[15:0];
    else if (a >= 8'h08 && a < 8'h88) begin
      int idx = (int'(a) - 8) / 8;
      if (a[2] == 1'b0) m_tab[idx][47:16] = d;
      else m_tab[idx][15:0] = d[31:16];
    end
  endfunction

  function automatic bit model(input logic [47:0] da);
    bit bc = (da == 48'hFFFF_FFFF_FFFF);
    bit mc = da[40] && !bc;
    bit uc = !da[40];
    bit hit = 0;
    for (int i = 0; i < NE; i++) if (m_en[i] && m_tab[i] == da) hit = 1;
    return (m_mode[0] && uc) || (m_mode[1] && mc) || (m_mode[2] && bc) || (m_mode[3] && hit);
  endfunction

  task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    mirror_wr(a, d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_frame(input logic [47:0] da, input int pre, input int extra,
                           input bit do_wr, input int wr_cyc, input logic [7:0] wa,
                           input logic [31:0] wd, input string tag);
    bit e = model(da);
    int len = pre + 6 + extra;
    int pc = pre + 7;
    for (int c = 0; c <= len + 2; c++) begin
      @(negedge clk);
      chk(dec_valid == (c == pc), "R6", 64'(dec_valid), 64'(c == pc));
      if (c == pc) chk(dec_accept == e, tag, 64'(dec_accept), 64'(e));
      else chk(dec_accept == 1'b0, "R10", 64'(dec_accept), 64'd0);
      cfg_we = 1'b0;
      if (c < len) begin
        rx_valid = 1'b1;
        rx_sof = (c == 0) || (c == pre);
        if (c >= pre && c < pre + 6) rx_byte = da[47 - 8*(c-pre) -: 8];
        else rx_byte = 8'($urandom);
      end else begin
        rx_valid = 1'b0; rx_sof = 1'b0;
      end
      if (do_wr && c == wr_cyc) begin
        cfg_we = 1'b1; cfg_addr = wa; cfg_wdata = wd;
        mirror_wr(wa, wd);
      end
    end
    cfg_we = 1'b0;
  endtask

  task automatic frame(input logic [47:0] da, input string tag);
    run_frame(da, 0, 0, 0, 0, 8'h0, 32'h0, tag);
  endtask

  function automatic logic [47:0] rnd_da(input int kind);
    logic [47:0] v = {$urandom, 16'($urandom)};
    case (kind)
      0: v = m_tab[$urandom_range(0, NE-1)];
      1: v = '1;
      2: v[40] = 1'b1;
      default: v[40] = 1'b0;
    endcase
    return v;
  endfunction

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd7321);
    m_mode = '0; m_en = '0;
    for (int i = 0; i < NE; i++) m_tab[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(dec_valid == 1'b0 && dec_accept == 1'b0, "R9", {dec_valid, dec_accept}, 64'd0);
    frame(48'hFFFF_FFFF_FFFF, "R9");
    frame(48'h0012_3456_789A, "R9");

    // R1: slot layout, junk in low-word bits 15:0
    cfg_write(8'h20, 32'h02AA_BBCC);
    cfg_write(8'h24, 32'hDDEE_1234);
    cfg_write(8'h04, 32'h0000_0008);
    cfg_write(8'h00, 32'h0000_0010);
    frame(48'h02AA_BBCC_DDEE, "R1");
    frame(48'h02AA_BBCC_1234, "R1");
    frame(48'hCCBB_AA02_EEDD, "R1");
    // R2: enable gating, last slot
    cfg_write(8'h04, 32'h0000_0000);
    frame(48'h02AA_BBCC_DDEE, "R2");
    cfg_write(8'h80, 32'h0A0B_0C0D);
    cfg_write(8'h84, 32'h0E0F_0000);
    cfg_write(8'h04, 32'h0000_8000);
    frame(48'h0A0B_0C0D_0E0F, "R2");
    frame(48'h02AA_BBCC_DDEE, "R2");
    // R3: mode bits, bit 3 ignored
    cfg_write(8'h00, 32'hFFFF_FFE8);
    frame(48'h0012_3456_789A, "R3");
    frame(48'h0112_3456_789A, "R3");
    cfg_write(8'h00, 32'h0000_0001);
    frame(48'h0012_3456_789A, "R3");
    frame(48'h0112_3456_789A, "R3");
    cfg_write(8'h00, 32'h0000_0002);
    frame(48'h0312_3456_789A, "R3");
    frame(48'h0212_3456_789A, "R3");
    // R4: broadcast is not multicast
    frame(48'hFFFF_FFFF_FFFF, "R4");
    cfg_write(8'h00, 32'h0000_0004);
    frame(48'hFFFF_FFFF_FFFF, "R4");
    frame(48'hFFFF_FFFF_FFFE, "R4");
    // R5: promiscuous and compare+broadcast
    cfg_write(8'h00, 32'h0000_0017);
    frame(48'h0012_3456_789A, "R5");
    frame(48'h0112_3456_789A, "R5");
    frame(48'hFFFF_FFFF_FFFF, "R5");
    cfg_write(8'h00, 32'h0000_0014);
    frame(48'h0012_3456_789A, "R5");
    frame(48'hFFFF_FFFF_FFFF, "R5");
    frame(48'h0A0B_0C0D_0E0F, "R5");
    // R6: trailing payload bytes
    run_frame(48'h0A0B_0C0D_0E0F, 0, 12, 0, 0, 8'h0, 32'h0, "R6");
    // R7: restart mid address
    run_frame(48'h0A0B_0C0D_0E0F, 3, 2, 0, 0, 8'h0, 32'h0, "R7");
    run_frame(48'h0012_3456_789A, 4, 0, 0, 0, 8'h0, 32'h0, "R7");
    // R8: write mid frame
    run_frame(48'h0012_3456_789A, 0, 0, 1, 3, 8'h00, 32'h0000_0001, "R8");
    frame(48'h0012_3456_789A, "R8");
    run_frame(48'h0A0B_0C0D_0E0F, 0, 2, 1, 2, 8'h04, 32'h0000_0000, "R8");
    frame(48'h0A0B_0C0D_0E0F, "R8");

    // constrained random
    for (int n = 0; n < 400; n++) begin
      if (n % 10 == 0) begin
        cfg_write(8'h00, $urandom);
        cfg_write(8'h04, $urandom);
        for (int k = 0; k < 3; k++) begin
          logic [7:0] base = 8'(8 + 8 * $urandom_range(0, NE-1));
          cfg_write(base, $urandom);
          cfg_write(base + 8'd4, $urandom);
        end
      end
      run_frame(rnd_da($urandom_range(0, 3)), ($urandom_range(0, 3) == 0) ? $urandom_range(1, 5) : 0,
                $urandom_range(0, 4), 0, 0, 8'h0, 32'h0, "R5");
    end

    if (!done_flag) begin
      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule